// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block sits on a 64-bit, four-beats-per-clock data path and limits wire switching by inverting each 16-bit lane group independently. On the transmit side it accepts a 256-bit chunk (four 64-bit beats) qualified by a valid strobe. For every beat and every group it counts how many wires would toggle relative to the level that group last carried. If more than half would toggle it sends the complement and raises that group's inversion flag. Data, flags and the bus status indications all leave the block active low, from registers.

Within a chunk, each beat is compared with the beat sent just before it. Beat 0 of a chunk is compared with the final beat of the previous chunk. After reset every wire sits at logical 0, which is a high level. The receive side takes wire-level beats and flags and restores the true data one clock later. The transmit side also drives two indications. Ready marks the clock that carries a transfer. Busy covers the whole time the agent owns the data path and releases one clock after the last transfer.

Top module: `grp_dbi_codec`

## Requirements
- R1: Beat b of a chunk occupies bits 64*b+63:64*b, and beat 0 is sent first. Group g of a beat is bits 16*g+15:16*g of that beat. Its inversion flag is bit 4*b+g of the flag vectors.
- R2: A group is sent inverted exactly when 9 or more of its 16 bits differ from the reference logical level. Exactly 8 differing bits leave it uninverted.
- R3: A group's flag is asserted (logical 1) exactly when that group carries the complement of its true data.
- R4: Data and flags are active low on the wires: logical 1 is driven as 0, and the idle state after reset is all ones.
- R5: For beats 1 to 3 the reference is the logical level of the same group in the preceding beat. For beat 0 it is beat 3 of the previous chunk, or all zeros after reset.
- R6: The receiver output, valid one clock after rx_rdy_n is sampled low, equals the true data, with flagged groups inverted back.
- R7: wire_rdy_n is low for exactly the clock after each clock in which tx_valid is sampled high.
- R8: wire_busy_n is low whenever wire_rdy_n is low and in the single clock after it, and high otherwise.
- R9: After reset, wire_data_n and wire_inv_n are all ones, wire_rdy_n and wire_busy_n are high, and rx_valid is low.
- R10: While no transfer is made, wire_data_n and wire_inv_n hold their last values.
- R11: No group ever shows more than 8 wire transitions between consecutive beats, including across chunk boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Chunk on tx_line is accepted this clock |
| tx_line | input | 256 | Four true-data beats, beat 0 in the low 64 bits |
| wire_data_n | output | 256 | Active-low wire data, four beats |
| wire_inv_n | output | 16 | Active-low inversion flags, bit 4*b+g |
| wire_rdy_n | output | 1 | Active-low data-ready |
| wire_busy_n | output | 1 | Active-low data-busy |
| rx_data_n | input | 256 | Received active-low wire data |
| rx_inv_n | input | 16 | Received active-low inversion flags |
| rx_rdy_n | input | 1 | Received active-low data-ready |
| rx_line | output | 256 | Restored true data |
| rx_valid | output | 1 | rx_line holds a restored chunk |

## Verification
Some properties are checked on every clock. The switching bound holds for each group between adjacent beats and across chunk boundaries. The wires hold steady between transfers, and ready and busy follow tx_valid with the proper timing and nesting. Other behaviours only the bench scenarios can show. These are the exact-8 versus 9-toggle threshold, the reset reference of all zeros, and the correct choice of complement per group. The bench also confirms bit-exact recovery by the receiver over a loopback, comparing against a model of the encoding rule.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int unsigned GROUP_W = 16;
    localparam int unsigned GROUPS  = 4;
    localparam int unsigned BEATS   = 4;
    localparam int unsigned BUS_W   = GROUP_W * GROUPS;
    localparam int unsigned LINE_W  = BUS_W * BEATS;
    localparam int unsigned FLAG_W  = GROUPS * BEATS;
    localparam int unsigned CNT_W   = $clog2(GROUP_W + 1);

    typedef logic [GROUP_W-1:0] grp_t;

    // number of set bits in a group-wide vector
    function automatic logic [CNT_W-1:0] ones_in(input grp_t v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/dbi_grp_enc.sv
// One group, one beat: decide inversion against the reference logical level.
module dbi_grp_enc
    import dbi_pkg::*;
(
    input  grp_t data,
    input  grp_t ref_lvl,
    output grp_t out_lvl,
    output logic inv
);
    localparam int unsigned HALF = GROUP_W / 2;

    logic [CNT_W-1:0] flips;

    always_comb begin
        flips   = ones_in(data ^ ref_lvl);
        inv     = (flips > CNT_W'(HALF));
        out_lvl = inv ? ~data : data;
    end
endmodule

// File: rtl/dbi_grp_dec.sv
// One group, one beat: recover true data from active-low wires and flag.
module dbi_grp_dec
    import dbi_pkg::*;
(
    input  grp_t wire_n,
    input  logic flag_n,
    output grp_t data
);
    grp_t lvl;

    always_comb begin
        lvl  = ~wire_n;
        data = flag_n ? lvl : ~lvl;
    end
endmodule

// File: rtl/grp_dbi_codec.sv
module grp_dbi_codec
    import dbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [LINE_W-1:0] tx_line,
    output logic [LINE_W-1:0] wire_data_n,
    output logic [FLAG_W-1:0] wire_inv_n,
    output logic              wire_rdy_n,
    output logic              wire_busy_n,
    input  logic [LINE_W-1:0] rx_data_n,
    input  logic [FLAG_W-1:0] rx_inv_n,
    input  logic              rx_rdy_n,
    output logic [LINE_W-1:0] rx_line,
    output logic              rx_valid
);
    typedef struct packed {
        logic [LINE_W-1:0] data_n;
        logic [FLAG_W-1:0] inv_n;
        logic              rdy_n;
        logic              busy_n;
        logic [LINE_W-1:0] rx_line;
        logic              rx_valid;
    } state_t;

    state_t st_d, st_q;

    grp_t enc_ref [BEATS][GROUPS];
    grp_t enc_lvl [BEATS][GROUPS];
    logic enc_inv [BEATS][GROUPS];
    grp_t dec_dat [BEATS][GROUPS];

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            localparam int unsigned LO = b * BUS_W + g * GROUP_W;
            if (b == 0) begin : g_first
                localparam int unsigned LAST = (BEATS - 1) * BUS_W + g * GROUP_W;
                assign enc_ref[b][g] = ~st_q.data_n[LAST +: GROUP_W];
            end else begin : g_chain
                assign enc_ref[b][g] = enc_lvl[b-1][g];
            end

            dbi_grp_enc u_enc (
                .data    (tx_line[LO +: GROUP_W]),
                .ref_lvl (enc_ref[b][g]),
                .out_lvl (enc_lvl[b][g]),
                .inv     (enc_inv[b][g])
            );

            dbi_grp_dec u_dec (
                .wire_n (rx_data_n[LO +: GROUP_W]),
                .flag_n (rx_inv_n[b * GROUPS + g]),
                .data   (dec_dat[b][g])
            );
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.rdy_n    = ~tx_valid;
        st_d.busy_n   = ~(tx_valid | ~st_q.rdy_n);
        st_d.rx_valid = ~rx_rdy_n;
        if (tx_valid) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    st_d.data_n[b*BUS_W + g*GROUP_W +: GROUP_W] = ~enc_lvl[b][g];
                    st_d.inv_n[b*GROUPS + g]                   = ~enc_inv[b][g];
                end
            end
        end
        if (!rx_rdy_n) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    st_d.rx_line[b*BUS_W + g*GROUP_W +: GROUP_W] = dec_dat[b][g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data_n   <= '1;
            st_q.inv_n    <= '1;
            st_q.rdy_n    <= 1'b1;
            st_q.busy_n   <= 1'b1;
            st_q.rx_line  <= '0;
            st_q.rx_valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wire_data_n = st_q.data_n;
    assign wire_inv_n  = st_q.inv_n;
    assign wire_rdy_n  = st_q.rdy_n;
    assign wire_busy_n = st_q.busy_n;
    assign rx_line     = st_q.rx_line;
    assign rx_valid    = st_q.rx_valid;
endmodule

// File: rtl/grp_dbi_codec_chk.sv
module grp_dbi_codec_chk
    import dbi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [LINE_W-1:0] wire_data_n,
    input logic [FLAG_W-1:0] wire_inv_n,
    input logic              wire_rdy_n,
    input logic              wire_busy_n,
    input logic              rx_rdy_n,
    input logic              rx_valid
);
    localparam int unsigned LIMIT = GROUP_W / 2;

    p_rdy_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !wire_rdy_n);
    p_rdy_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> wire_rdy_n);
    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wire_rdy_n |-> !wire_busy_n);
    p_busy_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wire_rdy_n |=> !wire_busy_n);
    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wire_busy_n |-> (!wire_rdy_n || $past(!wire_rdy_n)));
    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wire_rdy_n |-> ($stable(wire_data_n) && $stable(wire_inv_n)));
    p_rx_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_rdy_n |=> rx_valid);

    for (genvar g = 0; g < GROUPS; g++) begin : g_lim
        localparam int unsigned LASTLO = (BEATS - 1) * BUS_W + g * GROUP_W;
        p_cross_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !wire_rdy_n |-> ($countones(wire_data_n[g*GROUP_W +: GROUP_W]
                                        ^ $past(wire_data_n[LASTLO +: GROUP_W])) <= LIMIT));
        for (genvar b = 1; b < BEATS; b++) begin : g_in
            localparam int unsigned LO = b * BUS_W + g * GROUP_W;
            p_inner_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(wire_data_n[LO +: GROUP_W]
                           ^ wire_data_n[LO - BUS_W +: GROUP_W]) <= LIMIT);
        end
    end
endmodule

bind grp_dbi_codec grp_dbi_codec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .wire_data_n (wire_data_n),
    .wire_inv_n  (wire_inv_n),
    .wire_rdy_n  (wire_rdy_n),
    .wire_busy_n (wire_busy_n),
    .rx_rdy_n    (rx_rdy_n),
    .rx_valid    (rx_valid)
);

// File: tb/tb_grp_dbi_codec.sv
module tb_grp_dbi_codec;
    import dbi_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_valid = 1'b0;
    logic [LINE_W-1:0] tx_line = '0;
    logic [LINE_W-1:0] wire_data_n;
    logic [FLAG_W-1:0] wire_inv_n;
    logic              wire_rdy_n, wire_busy_n;
    logic [LINE_W-1:0] rx_line;
    logic              rx_valid;

    int checks = 0;
    int errors = 0;
    logic [BUS_W-1:0] ref_m = '0;   // model reference: logical level of last beat
    logic [LINE_W-1:0] exp_w;
    logic [FLAG_W-1:0] exp_f;

    always #2.5 clk = ~clk;

    grp_dbi_codec dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_line(tx_line),
        .wire_data_n(wire_data_n), .wire_inv_n(wire_inv_n),
        .wire_rdy_n(wire_rdy_n), .wire_busy_n(wire_busy_n),
        .rx_data_n(wire_data_n), .rx_inv_n(wire_inv_n), .rx_rdy_n(wire_rdy_n),
        .rx_line(rx_line), .rx_valid(rx_valid)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected wires from R1..R5, updating the model reference
    task automatic model(input logic [LINE_W-1:0] line);
        for (int b = 0; b < BEATS; b++) begin
            for (int g = 0; g < GROUPS; g++) begin
                logic [GROUP_W-1:0] d, r, lv;
                logic f;
                d = line[b*BUS_W + g*GROUP_W +: GROUP_W];
                r = ref_m[g*GROUP_W +: GROUP_W];
                f = ($countones(d ^ r) >= 9);
                lv = f ? ~d : d;
                exp_w[b*BUS_W + g*GROUP_W +: GROUP_W] = ~lv;
                exp_f[b*GROUPS + g] = ~f;
                ref_m[g*GROUP_W +: GROUP_W] = lv;
            end
        end
    endtask

    // send one chunk, check wires, ready/busy, then loopback recovery
    task automatic send(input logic [LINE_W-1:0] line, input string tag);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_line  = line;
        model(line);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(wire_data_n == exp_w, {tag, " R2 R3 R4 R5 wire data"}, wire_data_n, exp_w);
        chk(wire_inv_n == exp_f, {tag, " R1 R3 flags"}, LINE_W'(wire_inv_n), LINE_W'(exp_f));
        chk(!wire_rdy_n && !wire_busy_n, {tag, " R7 R8 rdy/busy low"},
            LINE_W'({wire_rdy_n, wire_busy_n}), '0);
        @(negedge clk);
        chk(rx_valid && rx_line == line, {tag, " R6 recovery"}, rx_line, line);
        chk(wire_rdy_n && !wire_busy_n, {tag, " R7 R8 busy tail"},
            LINE_W'({wire_rdy_n, wire_busy_n}), LINE_W'(2'b10));
    endtask

    task automatic t_reset;
        chk(wire_data_n == '1 && wire_inv_n == '1, "R9 R4 idle wires",
            wire_data_n, '1);
        chk(wire_rdy_n && wire_busy_n && !rx_valid, "R9 status",
            LINE_W'({wire_rdy_n, wire_busy_n, rx_valid}), LINE_W'(3'b110));
    endtask

    task automatic t_threshold;
        logic [LINE_W-1:0] l;
        // beat0 group0: 8 toggles from reset ref 0 -> no inversion (R2, R5)
        // beat0 group1: 9 toggles -> inverted (R2)
        l = '0;
        l[15:0]  = 16'h00FF;
        l[31:16] = 16'h01FF;
        send(l, "threshold");
        chk(wire_inv_n[0] == 1'b1 && wire_inv_n[1] == 1'b0, "R2 8 vs 9 toggles",
            LINE_W'(wire_inv_n[1:0]), LINE_W'(2'b01));
    endtask

    task automatic t_idle_hold;
        logic [LINE_W-1:0] w;
        logic [FLAG_W-1:0] f;
        w = wire_data_n;
        f = wire_inv_n;
        repeat (3) @(negedge clk);
        chk(wire_data_n == w && wire_inv_n == f, "R10 hold while idle", wire_data_n, w);
        chk(wire_busy_n && wire_rdy_n, "R8 released", LINE_W'(wire_busy_n), LINE_W'(1));
    endtask

    task automatic t_patterns;
        send({LINE_W{1'b1}}, "all ones");
        send({LINE_W/2{2'b01}}, "alternating");
        send('0, "all zeros");
        send({{(LINE_W-BUS_W){1'b0}}, {BUS_W{1'b1}}}, "single beat ones");
    endtask

    task automatic t_back_to_back;
        logic [LINE_W-1:0] a, b;
        a = {8{32'hA5C3_0FF1}};
        b = {8{32'h5A3C_F00E}};
        @(negedge clk);
        tx_valid = 1'b1; tx_line = a; model(a);
        @(negedge clk);
        chk(wire_data_n == exp_w, "R5 back-to-back first", wire_data_n, exp_w);
        tx_line = b; model(b);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(wire_data_n == exp_w && wire_inv_n == exp_f, "R5 R11 back-to-back second",
            wire_data_n, exp_w);
        chk(rx_valid && rx_line == a, "R6 back-to-back recover first", rx_line, a);
        chk(!wire_busy_n, "R8 busy held across run", LINE_W'(wire_busy_n), '0);
        @(negedge clk);
        chk(rx_valid && rx_line == b, "R6 back-to-back recover second", rx_line, b);
        @(negedge clk);
    endtask

    task automatic t_random;
        logic [LINE_W-1:0] l;
        logic [LINE_W-1:0] prev;
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < LINE_W/32; k++) begin
                l[k*32 +: 32] = $urandom();
            end
            if (n % 3 == 0) l = l & {LINE_W/32{32'hFFFF_00F0}};
            prev = {LINE_W{1'b0}};
            prev[LINE_W-1 -: BUS_W] = wire_data_n[LINE_W-1 -: BUS_W];
            send(l, "random");
            // R11: transitions per group between consecutive beats at the wires
            for (int b = 0; b < BEATS; b++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    logic [GROUP_W-1:0] cur, pre;
                    cur = wire_data_n[b*BUS_W + g*GROUP_W +: GROUP_W];
                    pre = (b == 0) ? prev[(BEATS-1)*BUS_W + g*GROUP_W +: GROUP_W]
                                   : wire_data_n[(b-1)*BUS_W + g*GROUP_W +: GROUP_W];
                    chk($countones(cur ^ pre) <= 8, "R11 toggle bound",
                        LINE_W'($countones(cur ^ pre)), LINE_W'(8));
                end
            end
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_threshold();
                t_idle_hold();
                t_patterns();
                t_back_to_back();
                t_random();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule